// File: doc/BRIEF.md
# Multi-Instance Watchdog Register Front End

This block is the APB3 register front end for a set of independent watchdog timers. It decodes a 12-bit address space with 32-bit data. It holds each timer's configuration: enable, write-once lock, prescaler reload, count reload, kick-window threshold and interrupt mask. These values drive the counting cores as plain level outputs. Kick writes and write-one-to-clear writes become single-cycle strobes towards the cores and the interrupt combiner. Live status and pending flags from those units come back on reads.

Software finds the build-time shape of the block in a read-only description word at 0x008. The per-timer banks follow from 0x00C at a stride of 0x20. The counting and interrupt combining sit outside this block.

Top module: `wdg_apb_regs`

## Requirements
- R1: The word at 0x008 reads {6'b0, lock feature present, window feature present, prescaler width[7:0], counter width[7:0], instance count[7:0]}, with the count in bits [7:0] and the lock flag in bit 25. Writes to it are ignored.
- R2: Instance i owns word-aligned addresses 0x00C + i*0x20 + off. The offsets are: +0x00 control (bit0 enable, bit1 lock), +0x04 prescaler, +0x08 reload, +0x0C window threshold, +0x10 status, +0x14 pending, +0x18 mask, +0x1C kick.
- R3: pready is always 1 and pslverr is always 0. Every transfer completes in its first access cycle.
- R4: After reset, enable and lock are 0, the prescaler and reload are all ones, and the window threshold and mask are 0.
- R5: A write in the access phase updates the addressed register of that instance only, at that clock edge. The value is truncated to the register width (the mask is 4 bits with windows, 2 without) and reads back zero-extended.
- R6: Any write to the kick offset raises that instance's kick_pulse bit for exactly the one cycle after the access edge, whatever the data. The kick offset reads 0.
- R7: The pending offset reads the st_pending input. A write to it drives irq_clear with the written low bits for the one cycle after the access edge, and stores nothing.
- R8: Status is read-only: bit0 enable, bit1 lock, bit2 st_in_window (0 without windows). Writes to it are ignored.
- R9: Writing 1 to control bit 1 sets the lock, which only reset clears. While locked, a control write with bit0 = 0 leaves enable at 1, and writes to the prescaler, reload and window threshold are ignored. Mask, kick and pending writes still act.
- R10: Without the window feature, the window threshold reads 0 and cannot be written. Without the lock feature, the lock never sets and configuration stays writable.
- R11: Addresses outside the info word and the instance banks read 0 and ignore writes. This covers misaligned addresses, addresses below 0x00C and banks at or beyond the instance count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| paddr | input | 12 | Byte address |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write transfer |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| cfg_enable | output | NUM_INST | Enable level per instance |
| cfg_lock | output | NUM_INST | Lock state per instance |
| cfg_prescale | output | NUM_INST*PRE_W | Prescaler reload per instance |
| cfg_timeout | output | NUM_INST*CNT_W | Count reload per instance |
| cfg_window | output | NUM_INST*CNT_W | Kick window threshold per instance |
| cfg_irq_mask | output | NUM_INST*IRQ_W | Interrupt source mask per instance |
| kick_pulse | output | NUM_INST | One-cycle kick strobe per instance |
| irq_clear | output | NUM_INST*IRQ_W | One-cycle write-one-to-clear strobes |
| st_in_window | input | NUM_INST | Counter-inside-window flag from each core |
| st_pending | input | NUM_INST*IRQ_W | Pending flags from the interrupt unit |

## Verification
The bench builds two copies of the block.

The first copy has three instances, 16-bit counters, 8-bit prescalers and both optional features. This brings into reach:
- truncation of wide writes;
- separation between neighbouring banks;
- the 4-bit interrupt layout;
- the unmapped bank just past the last instance;
- the full lock behaviour.

The second copy uses single-instance defaults with windows and locking compiled out. This covers the 32-bit widths in the info word, the window register reading 0, and a lock write that has no effect.

// File: rtl/wdg_regs_pkg.sv
// Shared constants and types for the watchdog register front end.
// Assumes a 12-bit byte address and 32-bit bus words.
package wdg_regs_pkg;

    localparam int          BUS_AW     = 12;
    localparam int          BUS_DW     = 32;
    localparam int          STRIDE_LG  = 5;        // 0x20 bytes per instance bank
    localparam logic [11:0] INFO_ADDR  = 12'h008;
    localparam logic [11:0] BANK_BASE  = 12'h00C;

    // Word slot inside an instance bank (byte offset / 4)
    typedef enum logic [2:0] {
        SLOT_CTRL  = 3'd0,
        SLOT_PRESC = 3'd1,
        SLOT_RELD  = 3'd2,
        SLOT_WIN   = 3'd3,
        SLOT_STAT  = 3'd4,
        SLOT_PEND  = 3'd5,
        SLOT_MASK  = 3'd6,
        SLOT_KICK  = 3'd7
    } bank_slot_e;

endpackage

// File: rtl/wdg_addr_dec.sv
// Address decoder: classifies a bus address as the info word, a slot in
// one instance bank, or unmapped. Assumes word-aligned access; any address
// with nonzero low bits is treated as unmapped.
module wdg_addr_dec
    import wdg_regs_pkg::*;
#(
    parameter int NUM_INST = 1,
    parameter int IDX_W    = 1
) (
    input  logic [BUS_AW-1:0] addr,
    output logic              info_hit,
    output logic              bank_hit,
    output logic [IDX_W-1:0]  bank_idx,
    output bank_slot_e        slot
);
    localparam logic [BUS_AW-1:0] NUM_A = BUS_AW'(NUM_INST);

    logic [BUS_AW-1:0] rel;
    logic [BUS_AW-1:0] rel_idx;

    // Split the address into instance index and slot
    always_comb begin
        rel      = addr - BANK_BASE;
        rel_idx  = rel >> STRIDE_LG;
        info_hit = (addr == INFO_ADDR);
        bank_hit = (addr >= BANK_BASE) && (addr[1:0] == 2'b00) && (rel_idx < NUM_A);
        bank_idx = IDX_W'(rel_idx);
        slot     = bank_slot_e'(rel[4:2]);
    end

endmodule

// File: rtl/wdg_inst_bank.sv
// Register bank of one watchdog instance: holds configuration, applies the
// lock rules, makes kick and clear strobes, and forms the read word.
// Assumes wr is high only in the access cycle of a write to this bank.
module wdg_inst_bank
    import wdg_regs_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRE_W      = 16,
    parameter int IRQ_W      = 2,
    parameter bit HAS_WINDOW = 1'b0,
    parameter bit HAS_LOCK   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  bank_slot_e        slot,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              in_window,
    input  logic [IRQ_W-1:0]  pending,
    output logic              enable,
    output logic              lock,
    output logic [PRE_W-1:0]  prescale,
    output logic [CNT_W-1:0]  timeout,
    output logic [CNT_W-1:0]  window,
    output logic [IRQ_W-1:0]  mask,
    output logic              kick,
    output logic [IRQ_W-1:0]  clr,
    output logic [BUS_DW-1:0] rword
);

    // Register updates and one-cycle strobes on a write to this bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            lock     <= 1'b0;
            prescale <= '1;
            timeout  <= '1;
            window   <= '0;
            mask     <= '0;
            kick     <= 1'b0;
            clr      <= '0;
        end else begin
            kick <= 1'b0;
            clr  <= '0;
            if (wr) begin
                case (slot)
                    SLOT_CTRL: begin
                        if (!lock || wdata[0]) enable <= wdata[0];
                        if (HAS_LOCK && wdata[1]) lock <= 1'b1;
                    end
                    SLOT_PRESC: if (!lock) prescale <= wdata[PRE_W-1:0];
                    SLOT_RELD:  if (!lock) timeout  <= wdata[CNT_W-1:0];
                    SLOT_WIN:   if (!lock && HAS_WINDOW) window <= wdata[CNT_W-1:0];
                    SLOT_PEND:  clr  <= wdata[IRQ_W-1:0];
                    SLOT_MASK:  mask <= wdata[IRQ_W-1:0];
                    SLOT_KICK:  kick <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Read word for the addressed slot
    always_comb begin
        case (slot)
            SLOT_CTRL:  rword = {30'b0, lock, enable};
            SLOT_PRESC: rword = BUS_DW'(prescale);
            SLOT_RELD:  rword = BUS_DW'(timeout);
            SLOT_WIN:   rword = BUS_DW'(window);
            SLOT_STAT:  rword = {29'b0, (HAS_WINDOW && in_window), lock, enable};
            SLOT_PEND:  rword = BUS_DW'(pending);
            SLOT_MASK:  rword = BUS_DW'(mask);
            default:    rword = '0;
        endcase
    end

endmodule

// File: rtl/wdg_rd_mux.sv
// Read data selector: picks the info word or the addressed bank's read
// word, and returns 0 for unmapped addresses or when no read is active.
module wdg_rd_mux
    import wdg_regs_pkg::*;
#(
    parameter int NUM_INST = 1,
    parameter int IDX_W    = 1
) (
    input  logic                       rd_en,
    input  logic                       info_hit,
    input  logic                       bank_hit,
    input  logic [IDX_W-1:0]           bank_idx,
    input  logic [BUS_DW-1:0]          info_word,
    input  logic [NUM_INST*BUS_DW-1:0] bank_words,
    output logic [BUS_DW-1:0]          rdata
);

    // Select the source of the read word
    always_comb begin
        rdata = '0;
        if (rd_en && info_hit) begin
            rdata = info_word;
        end else if (rd_en && bank_hit) begin
            for (int i = 0; i < NUM_INST; i++) begin
                if (bank_idx == IDX_W'(i)) rdata = bank_words[i*BUS_DW +: BUS_DW];
            end
        end
    end

endmodule

// File: rtl/wdg_apb_regs.sv
// APB3 register front end for NUM_INST watchdog instances. Zero wait
// states, no error responses. Assumes 1 <= NUM_INST <= 255, 1 <= CNT_W,
// PRE_W <= 32, and that every reachable bank fits the 12-bit address space.
module wdg_apb_regs
    import wdg_regs_pkg::*;
#(
    parameter int   NUM_INST   = 1,
    parameter int   CNT_W      = 32,
    parameter int   PRE_W      = 16,
    parameter bit   HAS_WINDOW = 1'b0,
    parameter bit   HAS_LOCK   = 1'b1,
    localparam int  IRQ_W      = HAS_WINDOW ? 4 : 2
) (
    input  logic                      pclk,
    input  logic                      presetn,
    input  logic [11:0]               paddr,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [31:0]               pwdata,
    output logic [31:0]               prdata,
    output logic                      pready,
    output logic                      pslverr,
    output logic [NUM_INST-1:0]       cfg_enable,
    output logic [NUM_INST-1:0]       cfg_lock,
    output logic [NUM_INST*PRE_W-1:0] cfg_prescale,
    output logic [NUM_INST*CNT_W-1:0] cfg_timeout,
    output logic [NUM_INST*CNT_W-1:0] cfg_window,
    output logic [NUM_INST*IRQ_W-1:0] cfg_irq_mask,
    output logic [NUM_INST-1:0]       kick_pulse,
    output logic [NUM_INST*IRQ_W-1:0] irq_clear,
    input  logic [NUM_INST-1:0]       st_in_window,
    input  logic [NUM_INST*IRQ_W-1:0] st_pending
);
    localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
    localparam logic [BUS_DW-1:0] INFO_WORD =
        {6'b0, HAS_LOCK, HAS_WINDOW, 8'(PRE_W), 8'(CNT_W), 8'(NUM_INST)};

    logic                       info_hit;
    logic                       bank_hit;
    logic [IDX_W-1:0]           bank_idx;
    bank_slot_e                 slot;
    logic                       wr_acc;
    logic                       rd_en;
    logic [NUM_INST*BUS_DW-1:0] bank_words;

    // Bus handshake: every access completes at once
    always_comb begin
        pready  = 1'b1;
        pslverr = 1'b0;
        wr_acc  = psel && penable && pwrite;
        rd_en   = psel && !pwrite;
    end

    wdg_addr_dec #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_dec (
        .addr     (paddr),
        .info_hit (info_hit),
        .bank_hit (bank_hit),
        .bank_idx (bank_idx),
        .slot     (slot)
    );

    for (genvar i = 0; i < NUM_INST; i++) begin : g_bank
        logic bank_wr;

        // Write enable for this instance only
        always_comb bank_wr = wr_acc && bank_hit && (bank_idx == IDX_W'(i));

        wdg_inst_bank #(
            .CNT_W(CNT_W), .PRE_W(PRE_W), .IRQ_W(IRQ_W),
            .HAS_WINDOW(HAS_WINDOW), .HAS_LOCK(HAS_LOCK)
        ) u_bank (
            .clk       (pclk),
            .rst_n     (presetn),
            .wr        (bank_wr),
            .slot      (slot),
            .wdata     (pwdata),
            .in_window (st_in_window[i]),
            .pending   (st_pending[i*IRQ_W +: IRQ_W]),
            .enable    (cfg_enable[i]),
            .lock      (cfg_lock[i]),
            .prescale  (cfg_prescale[i*PRE_W +: PRE_W]),
            .timeout   (cfg_timeout[i*CNT_W +: CNT_W]),
            .window    (cfg_window[i*CNT_W +: CNT_W]),
            .mask      (cfg_irq_mask[i*IRQ_W +: IRQ_W]),
            .kick      (kick_pulse[i]),
            .clr       (irq_clear[i*IRQ_W +: IRQ_W]),
            .rword     (bank_words[i*BUS_DW +: BUS_DW])
        );
    end

    wdg_rd_mux #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_rmux (
        .rd_en      (rd_en),
        .info_hit   (info_hit),
        .bank_hit   (bank_hit),
        .bank_idx   (bank_idx),
        .info_word  (INFO_WORD),
        .bank_words (bank_words),
        .rdata      (prdata)
    );

endmodule

// File: rtl/wdg_regs_chk.sv
// Property checker for wdg_apb_regs, attached by bind. Observes ports only.
module wdg_regs_chk #(
    parameter int NUM_INST   = 1,
    parameter int CNT_W      = 32,
    parameter int PRE_W      = 16,
    parameter bit HAS_WINDOW = 1'b0,
    localparam int IRQ_W     = HAS_WINDOW ? 4 : 2
) (
    input logic                      pclk,
    input logic                      presetn,
    input logic                      psel,
    input logic                      penable,
    input logic                      pwrite,
    input logic                      pready,
    input logic                      pslverr,
    input logic [NUM_INST-1:0]       cfg_enable,
    input logic [NUM_INST-1:0]       cfg_lock,
    input logic [NUM_INST*PRE_W-1:0] cfg_prescale,
    input logic [NUM_INST*CNT_W-1:0] cfg_timeout,
    input logic [NUM_INST-1:0]       kick_pulse,
    input logic [NUM_INST*IRQ_W-1:0] irq_clear
);

    // R3
    zero_wait_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);

    for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
        // R9
        lock_sticky_chk: assert property (@(posedge pclk) disable iff (!presetn)
            cfg_lock[i] |=> cfg_lock[i]);
        // R9
        locked_enable_chk: assert property (@(posedge pclk) disable iff (!presetn)
            (cfg_lock[i] && cfg_enable[i]) |=> cfg_enable[i]);
        // R9
        locked_reload_chk: assert property (@(posedge pclk) disable iff (!presetn)
            cfg_lock[i] |=> $stable(cfg_timeout[i*CNT_W +: CNT_W]));
        // R9
        locked_presc_chk: assert property (@(posedge pclk) disable iff (!presetn)
            cfg_lock[i] |=> $stable(cfg_prescale[i*PRE_W +: PRE_W]));
        // R6
        kick_cause_chk: assert property (@(posedge pclk) disable iff (!presetn)
            kick_pulse[i] |-> $past(psel && penable && pwrite));
        // R6
        kick_single_chk: assert property (@(posedge pclk) disable iff (!presetn)
            kick_pulse[i] |=> !kick_pulse[i] || $past(psel && penable && pwrite));
        // R7
        clear_cause_chk: assert property (@(posedge pclk) disable iff (!presetn)
            (|irq_clear[i*IRQ_W +: IRQ_W]) |-> $past(psel && penable && pwrite));
    end

endmodule

bind wdg_apb_regs wdg_regs_chk #(
    .NUM_INST(NUM_INST), .CNT_W(CNT_W), .PRE_W(PRE_W), .HAS_WINDOW(HAS_WINDOW)
) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pready(pready), .pslverr(pslverr),
    .cfg_enable(cfg_enable), .cfg_lock(cfg_lock), .cfg_prescale(cfg_prescale),
    .cfg_timeout(cfg_timeout), .kick_pulse(kick_pulse), .irq_clear(irq_clear)
);

// File: tb/sim_wdg_apb_regs.sv
// Bench: table-driven register walk on a three-instance build, then
// directed tests for reset, strobes, locking and a feature-less build.
module sim_wdg_apb_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] paddr = '0;
    logic        psel0 = 1'b0, psel1 = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    // u0: three instances, 16-bit counter, 8-bit prescaler, all features
    logic [31:0] prd0;
    logic        prdy0, perr0;
    logic [2:0]  en0, lk0, kick0, inwin0 = 3'b000;
    logic [23:0] pre0;
    logic [47:0] tmo0, win0;
    logic [11:0] msk0, clr0, pend0 = '0;

    wdg_apb_regs #(.NUM_INST(3), .CNT_W(16), .PRE_W(8), .HAS_WINDOW(1'b1), .HAS_LOCK(1'b1)) u0 (
        .pclk(clk), .presetn(rst_n), .paddr(paddr), .psel(psel0), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prd0), .pready(prdy0), .pslverr(perr0),
        .cfg_enable(en0), .cfg_lock(lk0), .cfg_prescale(pre0), .cfg_timeout(tmo0),
        .cfg_window(win0), .cfg_irq_mask(msk0), .kick_pulse(kick0), .irq_clear(clr0),
        .st_in_window(inwin0), .st_pending(pend0)
    );

    // u1: one instance, default widths, no window, no lock
    logic [31:0] prd1;
    logic        prdy1, perr1, en1, lk1, kick1, inwin1 = 1'b1;
    logic [15:0] pre1;
    logic [31:0] tmo1, win1;
    logic [1:0]  msk1, clr1, pend1 = '0;

    wdg_apb_regs #(.NUM_INST(1), .HAS_WINDOW(1'b0), .HAS_LOCK(1'b0)) u1 (
        .pclk(clk), .presetn(rst_n), .paddr(paddr), .psel(psel1), .penable(penable),
        .pwrite(pwrite), .pwdata(pwdata), .prdata(prd1), .pready(prdy1), .pslverr(perr1),
        .cfg_enable(en1), .cfg_lock(lk1), .cfg_prescale(pre1), .cfg_timeout(tmo1),
        .cfg_window(win1), .cfg_irq_mask(msk1), .kick_pulse(kick1), .irq_clear(clr1),
        .st_in_window(inwin1), .st_pending(pend1)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read value
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 12'h008, 32'h0308_1003, 4'd1},   // R1 info layout
        '{1'b1, 12'h010, 32'h1234_5678, 4'd5},   // R5 prescaler write
        '{1'b0, 12'h010, 32'h0000_0078, 4'd5},   // R5 truncated to 8 bits
        '{1'b1, 12'h014, 32'h0000_ABCD, 4'd5},
        '{1'b0, 12'h014, 32'h0000_ABCD, 4'd5},   // R5 reload
        '{1'b1, 12'h034, 32'h0001_0055, 4'd2},   // R2 instance 1 reload
        '{1'b0, 12'h034, 32'h0000_0055, 4'd2},
        '{1'b0, 12'h014, 32'h0000_ABCD, 4'd5},   // R5 instance 0 untouched
        '{1'b1, 12'h018, 32'h0000_0100, 4'd5},
        '{1'b0, 12'h018, 32'h0000_0100, 4'd5},   // R5 window threshold
        '{1'b1, 12'h064, 32'h0000_00FF, 4'd2},   // R2 instance 2 mask
        '{1'b0, 12'h064, 32'h0000_000F, 4'd5},   // R5 mask is 4 bits
        '{1'b1, 12'h008, 32'hFFFF_FFFF, 4'd1},
        '{1'b0, 12'h008, 32'h0308_1003, 4'd1},   // R1 info not writable
        '{1'b0, 12'h000, 32'h0000_0000, 4'd11},  // R11 below the banks
        '{1'b0, 12'h06C, 32'h0000_0000, 4'd11},  // R11 bank past the last instance
        '{1'b0, 12'h011, 32'h0000_0000, 4'd11},  // R11 misaligned
        '{1'b0, 12'h028, 32'h0000_0000, 4'd6},   // R6 kick reads 0
        '{1'b1, 12'h01C, 32'h0000_0007, 4'd8},
        '{1'b0, 12'h01C, 32'h0000_0000, 4'd8}    // R8 status not writable
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input bit dev, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
        psel0 = !dev; psel1 = dev;
        @(posedge clk); #1 penable = 1'b1;
        @(posedge clk); #1;
        psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input bit dev, input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        paddr = a; pwrite = 1'b0; penable = 1'b0;
        psel0 = !dev; psel1 = dev;
        @(posedge clk); #1 penable = 1'b1;
        #5 d = dev ? prd1 : prd0;
        check(dev ? (prdy1 && !perr1) : (prdy0 && !perr0), "R3 ready/no error", 64'(prdy0), 64'h1);
        @(posedge clk); #1;
        psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4 reset state at the ports and through reads
        check(en0 == 3'b0 && lk0 == 3'b0, "R4 enable/lock", 64'({en0, lk0}), 64'h0);
        check(tmo0 == 48'hFFFF_FFFF_FFFF && pre0 == 24'hFF_FFFF, "R4 reload/presc", 64'(tmo0), 64'hFFFF_FFFF_FFFF);
        check(win0 == '0 && msk0 == '0, "R4 window/mask", 64'({win0, msk0}), 64'h0);
        apb_read(1'b0, 12'h010, rd); check(rd == 32'hFF, "R4 prescaler read", 64'(rd), 64'hFF);
        apb_read(1'b0, 12'h014, rd); check(rd == 32'hFFFF, "R4 reload read", 64'(rd), 64'hFFFF);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) begin
                apb_write(1'b0, VEC[k].addr, VEC[k].data);
            end else begin
                apb_read(1'b0, VEC[k].addr, rd);
                n_run++;
                if (rd !== VEC[k].data) begin
                    n_fail++;
                    $display("FAIL R%0d row %0d: got %0h expected %0h", VEC[k].req, k, rd, VEC[k].data);
                end
            end
        end
        check(tmo0[31:16] == 16'h0055 && tmo0[15:0] == 16'hABCD, "R5 reload ports", 64'(tmo0), 64'h0055ABCD);

        // R6 kick strobe on instance 2 with zero data
        apb_write(1'b0, 12'h068, 32'h0);
        check(kick0 == 3'b100, "R6 kick pulse", 64'(kick0), 64'h4);
        @(posedge clk); #1;
        check(kick0 == 3'b000, "R6 kick one cycle", 64'(kick0), 64'h0);

        // R7 pending readback and clear strobe on instance 1
        pend0 = 12'h0A0;
        apb_read(1'b0, 12'h040, rd); check(rd == 32'hA, "R7 pending read", 64'(rd), 64'hA);
        apb_write(1'b0, 12'h040, 32'hFFFF_FFF6);
        check(clr0 == 12'h060, "R7 clear strobe", 64'(clr0), 64'h060);
        @(posedge clk); #1;
        check(clr0 == 12'h000, "R7 clear one cycle", 64'(clr0), 64'h0);
        apb_read(1'b0, 12'h040, rd); check(rd == 32'hA, "R7 nothing stored", 64'(rd), 64'hA);

        // R8 status with enable and window flag
        inwin0 = 3'b001;
        apb_write(1'b0, 12'h00C, 32'h1);
        apb_read(1'b0, 12'h01C, rd); check(rd == 32'h5, "R8 status bits", 64'(rd), 64'h5);

        // R9 lock rules on instance 0
        apb_write(1'b0, 12'h00C, 32'h3);
        apb_read(1'b0, 12'h00C, rd); check(rd == 32'h3, "R9 lock set", 64'(rd), 64'h3);
        apb_write(1'b0, 12'h00C, 32'h0);
        apb_read(1'b0, 12'h00C, rd); check(rd == 32'h3, "R9 disable ignored", 64'(rd), 64'h3);
        apb_write(1'b0, 12'h014, 32'h1111);
        apb_read(1'b0, 12'h014, rd); check(rd == 32'hABCD, "R9 reload frozen", 64'(rd), 64'hABCD);
        apb_write(1'b0, 12'h018, 32'h0022);
        apb_read(1'b0, 12'h018, rd); check(rd == 32'h0100, "R9 window frozen", 64'(rd), 64'h100);
        apb_write(1'b0, 12'h024, 32'h3);
        apb_read(1'b0, 12'h024, rd); check(rd == 32'h3, "R9 mask still writable", 64'(rd), 64'h3);
        check(lk0 == 3'b001, "R9 lock per instance", 64'(lk0), 64'h1);
        apb_write(1'b0, 12'h028, 32'h0);
        check(kick0 == 3'b001, "R9 kick while locked", 64'(kick0), 64'h1);

        // R10 and R1 on the feature-less build
        apb_read(1'b1, 12'h008, rd); check(rd == 32'h0010_2001, "R1 info defaults", 64'(rd), 64'h00102001);
        apb_write(1'b1, 12'h018, 32'h5);
        apb_read(1'b1, 12'h018, rd); check(rd == 32'h0, "R10 window reads 0", 64'(rd), 64'h0);
        apb_write(1'b1, 12'h00C, 32'h3);
        apb_read(1'b1, 12'h00C, rd); check(rd == 32'h1, "R10 lock absent", 64'(rd), 64'h1);
        apb_write(1'b1, 12'h010, 32'h42);
        apb_read(1'b1, 12'h010, rd); check(rd == 32'h42, "R10 config writable", 64'(rd), 64'h42);
        apb_read(1'b1, 12'h01C, rd); check(rd == 32'h1, "R10 status no window bit", 64'(rd), 64'h1);

        finish_run();
    end

endmodule